// File: doc/BRIEF.md
# Shared Buffer Block Pool Allocator

The block hands out fixed-size blocks of a shared buffer pool to numbered fetch clients. It keeps a global occupancy map of the pool and one ownership map for each client. Blocks listed in a static reservation map are occupied from reset onward, so no client can ever be given them.

A command interface accepts two operations. An allocate request names a client and a block count. The count is first reduced by that client's fixed quota. The whole request is then either granted or turned down for lack of space. When it is granted, the lowest free blocks are claimed one per clock. A release request names a pipe and frees the blocks of every client that belongs to that pipe. Clients are grouped by pipe: pipe p owns client ids 1+p*PLANES up to p*PLANES+PLANES, and client id 0 is unused.

Two pending masks record which pipes have been assigned and which have been released since the last commit pulse. Software-side programming of the pool is done elsewhere.

Top module: `smp_pool_alloc`

## Requirements
- R1: After reset, `occ_map` equals the reservation map `RSV_MAP`, every client ownership map is zero, both pending masks are zero, and `busy` and `done` are low.
- R2: An allocate request for a valid client is reduced by that client's quota, clamped at zero. The quota is field `CLIENT_QUOTA[4*id +: 4]`.
- R3: Available blocks are `NUM_BLKS` minus the ones in `occ_map`. If the reduced count exceeds that number, `done` and `err_nospc` rise together one clock edge after the accepting edge, and no map or mask changes.
- R4: A granted request of N>0 blocks keeps `busy` high and claims one block per clock, always the lowest-indexed free block. `done` rises N+1 edges after the accepting edge, with `busy` low.
- R5: Every granted block is set in both `occ_map` and the requesting client's map. The client's map is readable on `qry_map` when `qry_client` selects that client.
- R6: An allocate request for a client whose map is non-zero raises `warn_inuse` together with `done`. The request is still handled normally.
- R7: A release (`cmd_op`=1, `cmd_id`=pipe) clears the pipe's clients' blocks from `occ_map`, zeroes those client maps, and sets bit pipe of `released_mask`. `done` follows one edge later.
- R8: A successful allocate sets bit (id-1)/PLANES of `assigned_mask`. A `commit_clr` pulse clears both masks.
- R9: Reserved blocks stay set in `occ_map` whatever the sequence of commands.
- R10: An allocate request (`cmd_op`=0) for client 0, or for an id of `NUM_CLIENTS` or above, completes in one edge and changes no map or mask.
- R11: A request whose reduced count is zero completes in one edge with success, even when the pool is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when `busy` is low |
| cmd_op | input | 1 | 0 allocate, 1 release |
| cmd_id | input | CID_W | Client id (allocate) or pipe index (release) |
| cmd_count | input | CNT_W | Requested block count |
| commit_clr | input | 1 | Clears both pending masks |
| qry_client | input | CID_W | Selects the client map shown on `qry_map` |
| busy | output | 1 | Grant sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_nospc | output | 1 | Out-of-space rejection, valid with `done` |
| warn_inuse | output | 1 | Request for a client already owning blocks, valid with `done` |
| assigned_mask | output | NUM_PIPES | Pipes assigned since last commit |
| released_mask | output | NUM_PIPES | Pipes released since last commit |
| occ_map | output | NUM_BLKS | Global occupancy map |
| qry_map | output | NUM_BLKS | Ownership map of `qry_client` |

## Verification
The bench fills the pool until exactly the remaining space is asked for, then asks for one block more. A design with an off-by-one in the space test would either grant into reserved or owned blocks, or refuse a request that fits. After a release, the freed holes lie between occupied blocks, so an allocator that takes blocks from a moving pointer instead of the lowest free one puts blocks at the wrong indices. The bench also covers a quota that swallows the whole request while the pool is full, a repeat request to a client that already owns blocks, client id 0, and a reset in the middle of a grant. A design that rejects the first, stays silent or stalls on the second, touches state on the third, or keeps partial grants after the reset shows up in the maps and the masks.

// File: rtl/smp_pkg.sv
package smp_pkg;
    typedef enum logic {
        OP_ALLOC   = 1'b0,
        OP_RELEASE = 1'b1
    } op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } fsm_e;

    function automatic int unsigned clog2_min1(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((1 << w) < n) w++;
        return w;
    endfunction
endpackage

// File: rtl/smp_lowfree.sv
module smp_lowfree #(
    parameter int NB = 22,
    localparam int IDX_W = smp_pkg::clog2_min1(NB)
) (
    input  logic [NB-1:0]    occ,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/smp_popcnt.sv
module smp_popcnt #(
    parameter int NB = 22,
    localparam int CW = smp_pkg::clog2_min1(NB + 1)
) (
    input  logic [NB-1:0] vec,
    output logic [CW-1:0] ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < NB; i++) begin
            ones = ones + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/smp_owner_bank.sv
module smp_owner_bank #(
    parameter int NB    = 22,
    parameter int NC    = 13,
    parameter int CID_W = 4,
    localparam int IDX_W = smp_pkg::clog2_min1(NB)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [CID_W-1:0] set_cid,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [NC-1:0]    clr_sel,
    input  logic [CID_W-1:0] req_cid,
    input  logic [CID_W-1:0] qry_cid,
    output logic             req_owns,
    output logic [NB-1:0]    qry_map,
    output logic [NB-1:0]    rel_union
);
    logic [NB-1:0] own_q [NC];

    for (genvar c = 0; c < NC; c++) begin : g_client
        always_ff @(posedge clk) begin
            if (rst) begin
                own_q[c] <= '0;
            end else if (clr_sel[c]) begin
                own_q[c] <= '0;
            end else if (set_en && (set_cid == CID_W'(c))) begin
                own_q[c][set_idx] <= 1'b1;
            end
        end
    end

    always_comb begin
        rel_union = '0;
        req_owns  = 1'b0;
        qry_map   = '0;
        for (int c = 0; c < NC; c++) begin
            if (clr_sel[c]) rel_union = rel_union | own_q[c];
            if (req_cid == CID_W'(c)) req_owns = |own_q[c];
            if (qry_cid == CID_W'(c)) qry_map = own_q[c];
        end
    end
endmodule

// File: rtl/smp_pool_alloc.sv
module smp_pool_alloc #(
    parameter int NUM_BLKS = 22,
    parameter int NUM_PIPES = 4,
    parameter int PLANES = 3,
    parameter int CNT_W = 5,
    parameter int QUOTA_W = 4,
    parameter logic [NUM_BLKS-1:0] RSV_MAP = 'h23,
    parameter logic [(1+NUM_PIPES*PLANES)*QUOTA_W-1:0] CLIENT_QUOTA = 'h10020,
    localparam int NUM_CLIENTS = 1 + NUM_PIPES * PLANES,
    localparam int CID_W = smp_pkg::clog2_min1(NUM_CLIENTS),
    localparam int PIPE_W = smp_pkg::clog2_min1(NUM_PIPES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic                 cmd_op,
    input  logic [CID_W-1:0]     cmd_id,
    input  logic [CNT_W-1:0]     cmd_count,
    input  logic                 commit_clr,
    input  logic [CID_W-1:0]     qry_client,
    output logic                 busy,
    output logic                 done,
    output logic                 err_nospc,
    output logic                 warn_inuse,
    output logic [NUM_PIPES-1:0] assigned_mask,
    output logic [NUM_PIPES-1:0] released_mask,
    output logic [NUM_BLKS-1:0]  occ_map,
    output logic [NUM_BLKS-1:0]  qry_map
);
    import smp_pkg::*;

    localparam int IDX_W = clog2_min1(NUM_BLKS);
    localparam int AV_W  = clog2_min1(NUM_BLKS + 1);
    localparam int CMP_W = ((CNT_W > AV_W) ? CNT_W : AV_W) + 1;

    fsm_e                 st_q;
    logic [NUM_BLKS-1:0]  occ_q;
    logic [CNT_W-1:0]     remain_q;
    logic [CID_W-1:0]     gcid_q;
    logic [PIPE_W-1:0]    gpipe_q;
    logic                 done_q, err_q, warn_q;
    logic [NUM_PIPES-1:0] asg_q, rel_q;

    // Decode of the incoming command
    logic                 accept, is_alloc, is_release;
    logic                 cid_ok, rel_ok;
    logic [QUOTA_W-1:0]   quota;
    logic [CNT_W-1:0]     adj;
    logic [CID_W-1:0]     cid_m1;
    logic [PIPE_W-1:0]    pipe_of;
    logic [AV_W-1:0]      used, avail;
    logic                 too_big;

    assign accept     = cmd_valid && (st_q == ST_IDLE);
    assign is_alloc   = accept && (op_e'(cmd_op) == OP_ALLOC);
    assign is_release = accept && (op_e'(cmd_op) == OP_RELEASE);
    assign cid_ok     = (cmd_id != '0) && (int'(cmd_id) < NUM_CLIENTS);
    assign rel_ok     = int'(cmd_id) < NUM_PIPES;

    always_comb begin
        quota = '0;
        if (cid_ok) quota = CLIENT_QUOTA[cmd_id*QUOTA_W +: QUOTA_W];
    end

    assign adj     = (cmd_count > CNT_W'(quota)) ? (cmd_count - CNT_W'(quota)) : '0;
    assign cid_m1  = cmd_id - 1'b1;
    assign pipe_of = PIPE_W'(cid_m1 / CID_W'(PLANES));

    smp_popcnt #(.NB(NUM_BLKS)) u_pop (
        .vec  (occ_q),
        .ones (used)
    );

    assign avail   = AV_W'(NUM_BLKS) - used;
    assign too_big = CMP_W'(adj) > CMP_W'(avail);

    // Lowest free block search
    logic [IDX_W-1:0] pick_idx;
    logic             pick_found;
    logic             grant_fire;

    smp_lowfree #(.NB(NUM_BLKS)) u_pick (
        .occ   (occ_q),
        .idx   (pick_idx),
        .found (pick_found)
    );

    assign grant_fire = (st_q == ST_GRANT) && pick_found;

    // Clients belonging to the released pipe
    logic [NUM_CLIENTS-1:0] clr_sel;
    for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_sel
        if (c == 0) begin : g_unused
            assign clr_sel[c] = 1'b0;
        end else begin : g_used
            localparam int PIPE_OF_C = (c - 1) / PLANES;
            assign clr_sel[c] = is_release && rel_ok && (int'(cmd_id) == PIPE_OF_C);
        end
    end

    logic                req_owns;
    logic [NUM_BLKS-1:0] rel_union;

    smp_owner_bank #(.NB(NUM_BLKS), .NC(NUM_CLIENTS), .CID_W(CID_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .set_en    (grant_fire),
        .set_cid   (gcid_q),
        .set_idx   (pick_idx),
        .clr_sel   (clr_sel),
        .req_cid   (cmd_id),
        .qry_cid   (qry_client),
        .req_owns  (req_owns),
        .qry_map   (qry_map),
        .rel_union (rel_union)
    );

    // Mask update terms
    logic [NUM_PIPES-1:0] asg_set, rel_set;

    always_comb begin
        asg_set = '0;
        rel_set = '0;
        if (is_alloc && cid_ok && !too_big && (adj == '0)) asg_set[pipe_of] = 1'b1;
        if ((st_q == ST_GRANT) && (remain_q == CNT_W'(1))) asg_set[gpipe_q] = 1'b1;
        if (is_release && rel_ok) rel_set[cmd_id[PIPE_W-1:0]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            occ_q    <= RSV_MAP;
            remain_q <= '0;
            gcid_q   <= '0;
            gpipe_q  <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            warn_q   <= 1'b0;
            asg_q    <= '0;
            rel_q    <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            asg_q  <= (asg_q & ~{NUM_PIPES{commit_clr}}) | asg_set;
            rel_q  <= (rel_q & ~{NUM_PIPES{commit_clr}}) | rel_set;
            case (st_q)
                ST_IDLE: begin
                    if (is_release) begin
                        occ_q  <= occ_q & ~rel_union;
                        warn_q <= 1'b0;
                        done_q <= 1'b1;
                    end else if (is_alloc) begin
                        warn_q <= cid_ok && req_owns;
                        if (!cid_ok) begin
                            done_q <= 1'b1;
                        end else if (too_big) begin
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                        end else if (adj == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            remain_q <= adj;
                            gcid_q   <= cmd_id;
                            gpipe_q  <= pipe_of;
                            st_q     <= ST_GRANT;
                        end
                    end
                end
                ST_GRANT: begin
                    if (grant_fire) begin
                        occ_q[pick_idx] <= 1'b1;
                    end
                    remain_q <= remain_q - 1'b1;
                    if (remain_q == CNT_W'(1)) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (st_q == ST_GRANT);
    assign done          = done_q;
    assign err_nospc     = err_q;
    assign warn_inuse    = done_q && warn_q;
    assign assigned_mask = asg_q;
    assign released_mask = rel_q;
    assign occ_map       = occ_q;
endmodule

// File: rtl/smp_pool_alloc_chk.sv
module smp_pool_alloc_chk #(
    parameter int NUM_BLKS = 22,
    parameter logic [NUM_BLKS-1:0] RSV_MAP = 'h23
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_valid,
    input logic                busy,
    input logic                done,
    input logic                err_nospc,
    input logic [NUM_BLKS-1:0] occ_map,
    input logic [NUM_BLKS-1:0] qry_map
);
    a_r9_reserved_kept: assert property (@(posedge clk) disable iff (rst)
        (occ_map & RSV_MAP) == RSV_MAP);

    a_r5_owner_in_global: assert property (@(posedge clk) disable iff (rst)
        (qry_map & ~occ_map) == '0);

    a_r4_one_block_per_cycle: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($countones(occ_map) == $countones($past(occ_map)) + 1));

    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r3_reject_no_change: assert property (@(posedge clk) disable iff (rst)
        err_nospc |-> (done && $stable(occ_map)));

    a_r10_idle_holds_map: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cmd_valid) |=> $stable(occ_map));
endmodule

bind smp_pool_alloc smp_pool_alloc_chk #(.NUM_BLKS(NUM_BLKS), .RSV_MAP(RSV_MAP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .err_nospc (err_nospc),
    .occ_map   (occ_map),
    .qry_map   (qry_map)
);

// File: tb/tb_smp_pool_alloc.sv
module tb_smp_pool_alloc;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 22;
    localparam int NP = 4;
    localparam int NC = 13;
    localparam logic [NB-1:0] RSV = 22'h000023;

    typedef struct packed {
        bit       op;
        bit [3:0] id;
        bit [4:0] cnt;
        bit       e;
        bit       w;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd1,  5'd3,  1'b0, 1'b0},
        '{1'b0, 4'd2,  5'd4,  1'b0, 1'b0},
        '{1'b0, 4'd4,  5'd1,  1'b0, 1'b0},
        '{1'b0, 4'd5,  5'd5,  1'b0, 1'b0},
        '{1'b0, 4'd2,  5'd1,  1'b0, 1'b1},
        '{1'b0, 4'd7,  5'd20, 1'b1, 1'b0},
        '{1'b1, 4'd0,  5'd0,  1'b0, 1'b0},
        '{1'b0, 4'd7,  5'd8,  1'b0, 1'b0},
        '{1'b0, 4'd10, 5'd6,  1'b0, 1'b0},
        '{1'b0, 4'd11, 5'd1,  1'b1, 1'b0},
        '{1'b0, 4'd0,  5'd2,  1'b0, 1'b0},
        '{1'b0, 4'd1,  5'd2,  1'b0, 1'b0},
        '{1'b1, 4'd2,  5'd0,  1'b0, 1'b0},
        '{1'b0, 4'd8,  5'd9,  1'b1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_op = 1'b0;
    logic [3:0]    cmd_id = '0;
    logic [4:0]    cmd_count = '0;
    logic          commit_clr = 1'b0;
    logic [3:0]    qry_client = '0;
    logic          busy, done, err_nospc, warn_inuse;
    logic [NP-1:0] assigned_mask, released_mask;
    logic [NB-1:0] occ_map, qry_map;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit [NB-1:0] occ_m;
    bit [NB-1:0] own_m [NC];
    bit [NP-1:0] asg_m, rel_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    smp_pool_alloc dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_id(cmd_id), .cmd_count(cmd_count), .commit_clr(commit_clr),
        .qry_client(qry_client), .busy(busy), .done(done),
        .err_nospc(err_nospc), .warn_inuse(warn_inuse),
        .assigned_mask(assigned_mask), .released_mask(released_mask),
        .occ_map(occ_map), .qry_map(qry_map)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int quota_of(input int cid);
        if (cid == 1) return 2;
        if (cid == 4) return 1;
        return 0;
    endfunction

    task automatic reset_model();
        occ_m = RSV;
        for (int c = 0; c < NC; c++) own_m[c] = '0;
        asg_m = '0;
        rel_m = '0;
    endtask

    task automatic check_client(input string req, input int cid);
        qry_client = 4'(cid);
        #1;
        check(req, 32'(qry_map), 32'(own_m[cid]));
    endtask

    task automatic run_vec(input vec_t v);
        int lat, exp_lat, adj, avail, cid;
        bit ok;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = v.op;
        cmd_id    = v.id;
        cmd_count = v.cnt;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        exp_lat = 1;
        cid = int'(v.id);
        if (v.op) begin
            for (int c = 1; c < NC; c++) begin
                if ((c - 1) / 3 == cid) begin
                    occ_m    = occ_m & ~own_m[c];
                    own_m[c] = '0;
                end
            end
            if (cid < NP) rel_m[cid] = 1'b1;
        end else if (cid != 0 && cid < NC) begin
            adj   = (int'(v.cnt) > quota_of(cid)) ? int'(v.cnt) - quota_of(cid) : 0;
            avail = NB - $countones(occ_m);
            ok    = adj <= avail;
            if (ok) begin
                for (int k = 0; k < adj; k++) begin
                    for (int b = 0; b < NB; b++) begin
                        if (!occ_m[b]) begin
                            occ_m[b]      = 1'b1;
                            own_m[cid][b] = 1'b1;
                            break;
                        end
                    end
                end
                asg_m[(cid - 1) / 3] = 1'b1;
                if (adj > 0) exp_lat = adj + 1;
            end
        end
        check("R4 latency", 32'(lat), 32'(exp_lat));
        check("R3 err_nospc", 32'(err_nospc), 32'(v.e));
        check("R6 warn_inuse", 32'(warn_inuse), 32'(v.w));
        check("R5 occ_map", 32'(occ_map), 32'(occ_m));
        check("R8 assigned_mask", 32'(assigned_mask), 32'(asg_m));
        check("R7 released_mask", 32'(released_mask), 32'(rel_m));
        if (v.op) begin
            for (int c = 1; c < NC; c++)
                if ((c - 1) / 3 == cid) check_client("R7 client map cleared", c);
        end else if (cid != 0 && cid < NC) begin
            check_client("R5 client map", cid);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        reset_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 occ_map", 32'(occ_map), 32'(RSV));
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 masks", 32'({assigned_mask, released_mask}), 32'd0);
        for (int c = 0; c < NC; c++) check_client("R1 client map", c);
        rst = 1'b0;

        // Table walk: R2 quota, R3 space, R4 order, R6 warn, R7 release,
        // R9 reserved, R10 client 0 ignored, R11 zero request when full
        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i]);
            check("R9 reserved kept", 32'(occ_map & RSV), 32'(RSV));
        end

        // R8: commit clears both masks, maps untouched
        @(negedge clk);
        commit_clr = 1'b1;
        @(negedge clk);
        commit_clr = 1'b0;
        asg_m = '0;
        rel_m = '0;
        check("R8 commit assigned", 32'(assigned_mask), 32'd0);
        check("R8 commit released", 32'(released_mask), 32'd0);
        check("R8 commit occ", 32'(occ_map), 32'(occ_m));

        // R7: release of pipe 3 then R4 busy during grant, R1 reset mid-grant
        run_vec('{1'b1, 4'd3, 5'd0, 1'b0, 1'b0});
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 1'b0;
        cmd_id    = 4'd10;
        cmd_count = 5'd5;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R4 busy in grant", 32'(busy), 32'd1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reset_model();
        check("R1 occ after reset", 32'(occ_map), 32'(RSV));
        check("R1 busy after reset", 32'(busy), 32'd0);
        check("R1 masks after reset", 32'({assigned_mask, released_mask}), 32'd0);
        check_client("R1 client 10 after reset", 10);
        rst = 1'b0;

        // R2: quota larger than request for client 1 (quota 2, ask 1)
        run_vec('{1'b0, 4'd1, 5'd1, 1'b0, 1'b0});
        finish_run();
    end
endmodule